// File: doc/BRIEF.md
# Single-Cycle RV32 Subset Processor Core

This block is a 32-bit processor that executes a selected subset of the RISC-V base integer instruction set. Every instruction is fetched, decoded, executed and retired in one clock cycle. Program and data live in two separate word arrays inside the core. The core contains the program counter, a 32-entry register file, the immediate generator, the ALU, the branch comparator and the writeback selection.

The program array is filled through a dedicated write port while reset is held low. Execution starts at address 0 when reset is released. Loads and stores whose effective address has bit 31 set do not use the data array. They appear on an external I/O port, which a surrounding system uses for switches, lamps and displays.

The decoder accepts an irregular mix of operations. For example, it decodes the immediate XOR but not the register XOR, and the immediate logical right shift but not the immediate left shift. Any encoding outside the list is treated as a no-op.

Top module: `rv_sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and neither io_re_o nor io_we_o is asserted. After reset, every register reads 0 except x2, which reads 0x7FFFEFFC.
- R2: An instruction that is neither a branch nor JAL retires in one cycle, and pc_o advances by 4. The program word at pc_o is taken from the array word written at index pc_o[IMEM_AW+1:2] through the load port.
- R3: Opcode 0110011 executes six operations: ADD (funct3 000, funct7 0000000), SUB (000, 0100000), AND (111, 0000000), OR (110, 0000000), SLL (001, 0000000) and SRA (101, 0100000). Shifts use rs2[4:0].
- R4: Opcode 0010011 executes ADDI (000), ANDI (111), ORI (110) and XORI (100) with the sign-extended 12-bit immediate. It also executes SRLI (funct3 101, instr[31:25] = 0000000) with shamt instr[24:20].
- R5: Opcode 0000011 loads from the data array. LW (funct3 010) returns the full word. LB (000) sign-extends and LBU (100) zero-extends the byte in lane addr[1:0], where lane 0 is bits 7:0.
- R6: SW (opcode 0100011, funct3 010) writes rs2 to the data array word at the effective address rs1 + sign-extended immediate.
- R7: A load or store whose effective address has bit 31 set raises io_re_o or io_we_o for that cycle. It drives the address on io_addr_o and, for a store, rs2 on io_wdata_o, and it leaves the data array unchanged. Such a load takes its word from io_rdata_i with the same lane and extension rules as R5.
- R8: Opcode 1100011 branches to PC + B-immediate when its condition holds. The conditions are BEQ 000 and BNE 001; BLT 100 and BGE 101 compare as signed; BLTU 110 and BGEU 111 compare as unsigned. When the condition fails, the PC advances by 4.
- R9: JAL (opcode 1101111) writes PC+4 to rd and jumps to PC + J-immediate.
- R10: LUI (opcode 0110111) writes instr[31:12] followed by 12 zero bits to rd.
- R11: Writes to x0 are discarded, and x0 always reads as 0.
- R12: Any other opcode or funct combination does not write a register or the data array and raises no I/O strobe, and the PC advances by 4. This includes register XOR, immediate SLLI, MUL and SH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Program array write strobe |
| imem_waddr_i | input | IMEM_AW | Program array word index |
| imem_wdata_i | input | 32 | Program word to write |
| pc_o | output | 32 | Current program counter |
| io_re_o | output | 1 | I/O load strobe |
| io_we_o | output | 1 | I/O store strobe |
| io_addr_o | output | 32 | I/O byte address |
| io_wdata_o | output | 32 | I/O store data |
| io_rdata_i | input | 32 | I/O load word |

## Verification
Each run loads a generated program and executes it. The program reports results through I/O stores, and each reported word is compared with a value the bench computes itself.

Operand pairs come from a fixed list and from seeded random values. The fixed pairs are equal values, a negative value against a positive one, and all-ones against the largest positive value. These pairs separate the signed branch comparisons from the unsigned ones and show whether SRA shifts in copies of the sign bit.

Byte loads read lanes with the top bit set and with it clear, which tells sign extension apart from zero extension. A store to an I/O address that aliases the data array location shows whether I/O traffic leaks into the array. Unsupported encodings are placed between known register and memory values, so any unwanted write shows up in later reports.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;
  localparam int XLEN = 32;
  localparam int ILEN = 32;

  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_LUI    = 7'b0110111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK, WB_IMM} wb_sel_e;

  typedef struct packed {
    logic            rf_we;
    alu_op_e         alu_op;
    logic            use_imm;
    logic            mem_rd;
    logic            mem_wr;
    logic            ld_byte;
    logic            ld_uns;
    logic            branch;
    logic            jump;
    wb_sel_e         wb_sel;
    logic [2:0]      br_f3;
    logic [XLEN-1:0] imm;
  } ctrl_t;
endpackage

// File: rtl/rv_decode.sv
module rv_decode
  import rv_core_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output ctrl_t           ctrl_o
);
  logic [6:0] op, f7;
  logic [2:0] f3;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_j, imm_u;

  assign op = instr_i[6:0];
  assign f3 = instr_i[14:12];
  assign f7 = instr_i[31:25];

  assign imm_i = {{20{instr_i[31]}}, instr_i[31:20]};
  assign imm_s = {{20{instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
  assign imm_b = {{19{instr_i[31]}}, instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  assign imm_j = {{11{instr_i[31]}}, instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  assign imm_u = {instr_i[31:12], 12'b0};

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    ctrl_o.wb_sel = WB_ALU;
    ctrl_o.br_f3  = f3;
    ctrl_o.imm    = imm_i;
    case (op)
      OP_REG: begin
        if (f7 == 7'b0000000) begin
          ctrl_o.rf_we = 1'b1;
          case (f3)
            3'b000:  ctrl_o.alu_op = ALU_ADD;
            3'b111:  ctrl_o.alu_op = ALU_AND;
            3'b110:  ctrl_o.alu_op = ALU_OR;
            3'b001:  ctrl_o.alu_op = ALU_SLL;
            default: ctrl_o.rf_we  = 1'b0;
          endcase
        end else if (f7 == 7'b0100000) begin
          ctrl_o.rf_we = 1'b1;
          case (f3)
            3'b000:  ctrl_o.alu_op = ALU_SUB;
            3'b101:  ctrl_o.alu_op = ALU_SRA;
            default: ctrl_o.rf_we  = 1'b0;
          endcase
        end
      end
      OP_IMM: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.rf_we   = 1'b1;
        case (f3)
          3'b000:  ctrl_o.alu_op = ALU_ADD;
          3'b111:  ctrl_o.alu_op = ALU_AND;
          3'b110:  ctrl_o.alu_op = ALU_OR;
          3'b100:  ctrl_o.alu_op = ALU_XOR;
          3'b101: begin
            ctrl_o.alu_op = ALU_SRL;
            ctrl_o.rf_we  = (f7 == 7'b0000000);
          end
          default: ctrl_o.rf_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.wb_sel  = WB_MEM;
        case (f3)
          3'b010: begin ctrl_o.mem_rd = 1'b1; ctrl_o.rf_we = 1'b1; end
          3'b000: begin ctrl_o.mem_rd = 1'b1; ctrl_o.rf_we = 1'b1; ctrl_o.ld_byte = 1'b1; end
          3'b100: begin
            ctrl_o.mem_rd = 1'b1; ctrl_o.rf_we = 1'b1;
            ctrl_o.ld_byte = 1'b1; ctrl_o.ld_uns = 1'b1;
          end
          default: ;
        endcase
      end
      OP_STORE: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.imm     = imm_s;
        ctrl_o.mem_wr  = (f3 == 3'b010);
      end
      OP_BRANCH: begin
        ctrl_o.imm    = imm_b;
        ctrl_o.branch = (f3 != 3'b010) && (f3 != 3'b011);
      end
      OP_JAL: begin
        ctrl_o.imm    = imm_j;
        ctrl_o.jump   = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_sel = WB_LINK;
      end
      OP_LUI: begin
        ctrl_o.imm    = imm_u;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_sel = WB_IMM;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rv_regfile.sv
module rv_regfile #(
  parameter int          NREG    = 32,
  parameter int          WIDTH   = 32,
  parameter int          SP_IDX  = 2,
  parameter logic [31:0] SP_INIT = 32'h7FFF_EFFC,
  localparam int         AW      = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ra1_i,
  input  logic [AW-1:0]    ra2_i,
  output logic [WIDTH-1:0] rd1_o,
  output logic [WIDTH-1:0] rd2_o,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [WIDTH-1:0] wd_i
);
  logic [WIDTH-1:0] rf_q [NREG];

  // entry 0 is hard zero; no storage
  assign rf_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    localparam logic [WIDTH-1:0] RST_VAL = (g == SP_IDX) ? WIDTH'(SP_INIT) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          rf_q[g] <= RST_VAL;
      else if (we_i && wa_i == AW'(g))      rf_q[g] <= wd_i;
    end
  end

  assign rd1_o = rf_q[ra1_i];
  assign rd2_o = rf_q[ra2_i];
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_core_pkg::*;
#(
  parameter  int W   = XLEN,
  localparam int SHW = $clog2(W)
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLL: y_o = a_i << sh;
      ALU_SRL: y_o = a_i >> sh;
      default: y_o = W'($signed(a_i) >>> sh);
    endcase
  end
endmodule

// File: rtl/rv_branch.sv
module rv_branch #(
  parameter int W = 32
) (
  input  logic [2:0]   f3_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         take_o
);
  logic eq, lts, ltu;
  assign eq  = (a_i == b_i);
  assign lts = ($signed(a_i) < $signed(b_i));
  assign ltu = (a_i < b_i);

  always_comb begin
    case (f3_i)
      3'b000:  take_o = eq;
      3'b001:  take_o = !eq;
      3'b100:  take_o = lts;
      3'b101:  take_o = !lts;
      3'b110:  take_o = ltu;
      3'b111:  take_o = !ltu;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rv_sc_core.sv
module rv_sc_core
  import rv_core_pkg::*;
#(
  parameter  int          IMEM_AW = 10,  // 14 gives 64 KB
  parameter  int          DMEM_AW = 10,  // 14 gives 64 KB
  parameter  int          NREG    = 32,
  parameter  logic [31:0] SP_INIT = 32'h7FFF_EFFC,
  localparam int          RAW     = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_waddr_i,
  input  logic [ILEN-1:0]    imem_wdata_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               io_re_o,
  output logic               io_we_o,
  output logic [XLEN-1:0]    io_addr_o,
  output logic [XLEN-1:0]    io_wdata_o,
  input  logic [XLEN-1:0]    io_rdata_i
);
  logic [ILEN-1:0] imem [2**IMEM_AW];
  logic [XLEN-1:0] dmem [2**DMEM_AW];

  logic [XLEN-1:0] pc_q, pc_nxt, pc_inc, pc_tgt;
  logic [ILEN-1:0] instr;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_b, alu_y, ld_word, ld_val, wb_val;
  logic [7:0]      ld_byte;
  logic            is_io, take, dmem_we;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_waddr_i] <= imem_wdata_i;
  end

  assign instr = imem[pc_q[IMEM_AW+1:2]];

  rv_decode i_dec (.instr_i(instr), .ctrl_o(ctrl));

  rv_regfile #(.NREG(NREG), .WIDTH(XLEN), .SP_IDX(2), .SP_INIT(SP_INIT)) i_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (instr[15+:RAW]),
    .ra2_i (instr[20+:RAW]),
    .rd1_o (rs1_val),
    .rd2_o (rs2_val),
    .we_i  (ctrl.rf_we),
    .wa_i  (instr[7+:RAW]),
    .wd_i  (wb_val)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm : rs2_val;

  rv_alu #(.W(XLEN)) i_alu (.op_i(ctrl.alu_op), .a_i(rs1_val), .b_i(alu_b), .y_o(alu_y));

  rv_branch #(.W(XLEN)) i_br (.f3_i(ctrl.br_f3), .a_i(rs1_val), .b_i(rs2_val), .take_o(take));

  // negative effective address selects the I/O port
  assign is_io   = alu_y[XLEN-1];
  assign io_re_o = ctrl.mem_rd & is_io & rst_ni;
  assign io_we_o = ctrl.mem_wr & is_io & rst_ni;
  assign dmem_we = ctrl.mem_wr & ~is_io & rst_ni;
  assign io_addr_o  = alu_y;
  assign io_wdata_o = rs2_val;

  always_ff @(posedge clk_i) begin
    if (dmem_we) dmem[alu_y[DMEM_AW+1:2]] <= rs2_val;
  end

  assign ld_word = is_io ? io_rdata_i : dmem[alu_y[DMEM_AW+1:2]];
  assign ld_byte = ld_word[{alu_y[1:0], 3'b000}+:8];

  always_comb begin
    if (!ctrl.ld_byte)    ld_val = ld_word;
    else if (ctrl.ld_uns) ld_val = {{(XLEN-8){1'b0}}, ld_byte};
    else                  ld_val = {{(XLEN-8){ld_byte[7]}}, ld_byte};
  end

  assign pc_inc = pc_q + XLEN'(4);
  assign pc_tgt = pc_q + ctrl.imm;

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_val = ld_val;
      WB_LINK: wb_val = pc_inc;
      WB_IMM:  wb_val = ctrl.imm;
      default: wb_val = alu_y;
    endcase
  end

  assign pc_nxt = (ctrl.jump || (ctrl.branch && take)) ? pc_tgt : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/rv_sc_core_chk.sv
module rv_sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic        io_re_i,
  input logic        io_we_i,
  input logic [31:0] io_addr_i,
  input logic [6:0]  opcode_i
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_i == 32'h0 && !io_re_i && !io_we_i));

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i != 7'b1100011 && opcode_i != 7'b1101111) |=> pc_i == $past(pc_i) + 32'd4);

  // R7
  io_neg_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_re_i || io_we_i) |-> io_addr_i[31]);

  // R7
  io_one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_re_i && io_we_i));

  // R12
  io_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i != 7'b0000011 && opcode_i != 7'b0100011) |-> !(io_re_i || io_we_i));
endmodule

bind rv_sc_core rv_sc_core_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (pc_o),
  .io_re_i  (io_re_o),
  .io_we_i  (io_we_o),
  .io_addr_i(io_addr_o),
  .opcode_i (instr[6:0])
);

// File: tb/test_rv_sc_core.sv
module test_rv_sc_core;
  localparam int IAW = 10;
  localparam logic [31:0] IO_BASE = 32'hFFFF_F000;
  localparam logic [31:0] SP_RST  = 32'h7FFF_EFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [IAW-1:0] imem_wa = '0;
  logic [31:0] imem_wd = '0;
  logic [31:0] pc, io_addr, io_wdata, io_rdata;
  logic        io_re, io_we;

  always #10 clk = ~clk;

  rv_sc_core #(.IMEM_AW(IAW)) i_rv_sc_core (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_we_i(imem_we), .imem_waddr_i(imem_wa), .imem_wdata_i(imem_wd),
    .pc_o(pc), .io_re_o(io_re), .io_we_o(io_we),
    .io_addr_o(io_addr), .io_wdata_o(io_wdata), .io_rdata_i(io_rdata)
  );

  function automatic logic [31:0] io_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  always_comb io_rdata = io_word({io_addr[31:2], 2'b00});

  int total = 0, bad = 0;

  // capture of I/O traffic
  logic [31:0] cap_a [0:4095];
  logic [31:0] cap_d [0:4095];
  int cap_n = 0, rd_n = 0;
  always @(negedge clk) begin
    if (rst_n && io_we) begin
      cap_a[cap_n] <= io_addr;
      cap_d[cap_n] <= io_wdata;
      cap_n <= cap_n + 1;
    end
    if (rst_n && io_re) rd_n <= rd_n + 1;
  end

  // program builder
  logic [31:0] prog [0:511];
  int          plen;
  logic [31:0] exp_d [0:127];
  string       exp_t [0:127];
  int          n_exp;

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd);
    return {imm, rd, 7'b0110111};
  endfunction

  function automatic logic [31:0] sx12(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic li(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) >> 12;
    emit(enc_u(hi[19:0], rd));
    emit(enc_i(v[11:0], rd, 3'b000, rd, 7'b0010011));
  endtask

  task automatic out(input logic [4:0] rs, input logic [31:0] ev, input string tag);
    logic [11:0] off;
    off = 12'(4 * n_exp);
    emit(enc_s(off, rs, 5'd5, 3'b010));
    exp_d[n_exp] = ev;
    exp_t[n_exp] = tag;
    n_exp++;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic run_trial(input logic [31:0] a, input logic [31:0] b,
                           input logic [11:0] imm, input logic [4:0] sham, input logic [19:0] up);
    logic [2:0]  bf3 [6];
    logic        tk;
    int          cap0, rd0, jpc;
    logic [31:0] w;
    bf3 = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    plen = 0; n_exp = 0;

    emit(enc_u(20'hFFFFF, 5'd5));                     // R10 io base via LUI
    li(5'd6, a);
    li(5'd7, b);
    out(5'd2, SP_RST, "R1 sp reset");
    out(5'd15, 32'h0, "R1 reg reset");
    emit(enc_r(7'h00, 5'd7, 5'd6, 3'b000, 5'd8)); out(5'd8, a + b, "R3 add");
    emit(enc_r(7'h20, 5'd7, 5'd6, 3'b000, 5'd8)); out(5'd8, a - b, "R3 sub");
    emit(enc_r(7'h00, 5'd7, 5'd6, 3'b111, 5'd8)); out(5'd8, a & b, "R3 and");
    emit(enc_r(7'h00, 5'd7, 5'd6, 3'b110, 5'd8)); out(5'd8, a | b, "R3 or");
    emit(enc_r(7'h00, 5'd7, 5'd6, 3'b001, 5'd8)); out(5'd8, a << b[4:0], "R3 sll");
    emit(enc_r(7'h20, 5'd7, 5'd6, 3'b101, 5'd8));
    out(5'd8, 32'($signed(a) >>> b[4:0]), "R3 sra");
    emit(enc_i(imm, 5'd6, 3'b000, 5'd8, 7'b0010011)); out(5'd8, a + sx12(imm), "R4 addi");
    emit(enc_i(imm, 5'd6, 3'b111, 5'd8, 7'b0010011)); out(5'd8, a & sx12(imm), "R4 andi");
    emit(enc_i(imm, 5'd6, 3'b110, 5'd8, 7'b0010011)); out(5'd8, a | sx12(imm), "R4 ori");
    emit(enc_i(imm, 5'd6, 3'b100, 5'd8, 7'b0010011)); out(5'd8, a ^ sx12(imm), "R4 xori");
    emit(enc_i({7'b0, sham}, 5'd6, 3'b101, 5'd8, 7'b0010011)); out(5'd8, a >> sham, "R4 srli");
    emit(enc_u(up, 5'd16)); out(5'd16, {up, 12'h000}, "R10 lui");

    // branches: taken skips setting x9
    for (int k = 0; k < 6; k++) begin
      case (bf3[k])
        3'b000:  tk = (a == b);
        3'b001:  tk = (a != b);
        3'b100:  tk = ($signed(a) < $signed(b));
        3'b101:  tk = ($signed(a) >= $signed(b));
        3'b110:  tk = (a < b);
        default: tk = (a >= b);
      endcase
      emit(enc_i(12'h000, 5'd0, 3'b000, 5'd9, 7'b0010011));
      emit(enc_b(13'd8, 5'd7, 5'd6, bf3[k]));
      emit(enc_i(12'h001, 5'd0, 3'b000, 5'd9, 7'b0010011));
      out(5'd9, tk ? 32'h0 : 32'h1, "R8 branch");
    end

    // R9 jal
    jpc = plen * 4;
    emit(enc_j(21'd8, 5'd14));
    emit(enc_i(12'h001, 5'd0, 3'b000, 5'd15, 7'b0010011));
    out(5'd14, 32'(jpc + 4), "R9 jal link");
    out(5'd15, 32'h0, "R9 jal skip");

    // data memory
    emit(enc_s(12'h100, 5'd6, 5'd0, 3'b010));
    emit(enc_s(12'h100, 5'd7, 5'd5, 3'b010));               // aliasing I/O store
    exp_d[n_exp] = b; exp_t[n_exp] = "R7 io store"; n_exp++;  // offset 0x100 slot
    emit(enc_s(12'h101, 5'd7, 5'd0, 3'b001));               // SH unsupported
    emit(enc_i(12'h100, 5'd0, 3'b010, 5'd10, 7'b0000011)); out(5'd10, a, "R6 sw/lw");
    emit(enc_i(12'h101, 5'd0, 3'b000, 5'd11, 7'b0000011));
    out(5'd11, {{24{a[15]}}, a[15:8]}, "R5 lb");
    emit(enc_i(12'h103, 5'd0, 3'b100, 5'd11, 7'b0000011));
    out(5'd11, {24'h0, a[31:24]}, "R5 lbu");
    emit(enc_i(12'h103, 5'd0, 3'b000, 5'd11, 7'b0000011));
    out(5'd11, {{24{a[31]}}, a[31:24]}, "R5 lb hi");

    // I/O loads
    w = io_word(IO_BASE + 32'h0C0);
    emit(enc_i(12'h0C0, 5'd5, 3'b010, 5'd12, 7'b0000011)); out(5'd12, w, "R7 io lw");
    emit(enc_i(12'h0C3, 5'd5, 3'b000, 5'd12, 7'b0000011));
    out(5'd12, {{24{w[31]}}, w[31:24]}, "R7 io lb");
    emit(enc_i(12'h0C1, 5'd5, 3'b100, 5'd12, 7'b0000011));
    out(5'd12, {24'h0, w[15:8]}, "R7 io lbu");

    // R11 x0
    emit(enc_i(12'h05A, 5'd6, 3'b000, 5'd0, 7'b0010011));
    out(5'd0, 32'h0, "R11 x0");

    // R12 unsupported encodings leave x13 alone
    li(5'd13, b);
    emit(enc_r(7'h01, 5'd7, 5'd6, 3'b000, 5'd13));
    emit(enc_r(7'h00, 5'd7, 5'd6, 3'b100, 5'd13));
    emit(enc_i(12'h003, 5'd6, 3'b001, 5'd13, 7'b0010011));
    emit(enc_i(12'h403, 5'd6, 3'b101, 5'd13, 7'b0010011));
    emit(enc_s(12'h7F0, 5'd6, 5'd5, 3'b001));
    emit(32'h0000_007F);
    out(5'd13, b, "R12 no-op");
    emit(enc_j(21'd0, 5'd0));

    // load program under reset (R2)
    rst_n = 1'b0;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_wa = IAW'(i); imem_wd = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    check("R1 pc in reset", pc, 32'h0);
    check("R1 no strobe in reset", {31'h0, io_re | io_we}, 32'h0);
    cap0 = cap_n; rd0 = rd_n;
    rst_n = 1'b1;
    repeat (plen + 20) @(negedge clk);
    check("R2 final pc", pc, 32'(4 * (plen - 1)));
    check("R7 io reads", 32'(rd_n - rd0), 32'd3);
    check("R7 store count", 32'(cap_n - cap0), 32'(n_exp));
    for (int k = 0; k < n_exp && k < cap_n - cap0; k++) begin
      // the aliasing store lands at offset 0x100, all others at 4*k
      logic [31:0] ea;
      ea = (exp_t[k] == "R7 io store") ? IO_BASE + 32'h100 : IO_BASE + 32'(4 * k);
      check({exp_t[k], " addr"}, cap_a[cap0 + k], ea);
      check(exp_t[k], cap_d[cap0 + k], exp_d[k]);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (2) @(negedge clk);
    run_trial(32'h0000_0000, 32'h0000_0000, 12'h000, 5'd0, 20'h00000);
    run_trial(32'h0000_0005, 32'h0000_0005, 12'hFFF, 5'd31, 20'hFFFFF);
    run_trial(32'h8000_0000, 32'h0000_0001, 12'h800, 5'd1, 20'h80000);
    run_trial(32'hFFFF_FFFF, 32'h7FFF_FFFF, 12'h7FF, 5'd16, 20'h12345);
    run_trial(32'h80FF_7F80, 32'h8765_431F, 12'h0F0, 5'd4, 20'hABCDE);
    for (int t = 0; t < 12; t++)
      run_trial($urandom, $urandom, 12'($urandom), 5'($urandom), 20'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule